// File: doc/BRIEF.md
# Masked Associative Lookup Table with Entry Validity Types

This block is a small content-addressable memory. It holds `DEPTH` entries of `WIDTH` bits (16 × 64 by default). A search key, the comparand, is matched against every entry of one selected validity type at once. The search returns a hit flag, a flag for more than one hit, and the lowest hitting address. The block also reports the lowest address whose entry is Empty, and a flag for the case where no Empty entry is left.

Each entry is split into 16-bit segments. A configurable number of low segments form the compared key field. The segments above them carry associated data that never takes part in a search. A global bit mask can exclude further bits, so the effective key width can be anything from 0 to `WIDTH` bits. Two validity bits per entry give four types: Valid, Empty, Skip and RAM. A search started by loading the comparand, the mask or the split compares only Valid entries. An explicit search command names the type to compare.

A host drives one synchronous command per clock. The command fields are opcode, address, validity type and data. A two-state controller decides which clock evaluates a search. In `ST_IDLE` no search is pending. A search-starting command moves it to `ST_SEARCH` (IDLE→SEARCH). In `ST_SEARCH` the registered result is updated. Another search-starting command keeps it there (SEARCH→SEARCH). Any other cycle returns it to idle (SEARCH→IDLE).

Top module: `vcam_top`

## Requirements
- R1: Opcode 5 (SETV) sets the validity bits of entry `cmd_addr` to `cmd_vtype` = {skip, empty}: 2'b00 Valid, 2'b01 Empty, 2'b10 Skip, 2'b11 RAM.
- R2: Opcodes 2 (CMPND), 3 (MASK) and 4 (SPLIT) load the comparand, the mask and the split from `cmd_data`. Each of them then starts a search of Valid entries only.
- R3: Opcode 6 (SEARCH) searches only the entries whose type equals `cmd_vtype`.
- R4: The split is loaded from `cmd_data[1:0]` as the number of key segments minus one. Segment g (bits 16g+15..16g) is compared only when g ≤ split. Higher segments never affect a match.
- R5: A mask bit at 1 excludes that bit from every comparison. With an all-ones mask, every entry of the selected type hits.
- R6: `match_flag` is 1 when at least one entry hits. `multi_flag` is 1 when two or more entries hit. `match_addr` is the lowest hitting address, or 0 when nothing hits.
- R7: A search command sampled at edge E is evaluated at edge E+1, using the contents as they stand after E. A write or validity change sampled at E+1 does not affect that result. Results hold until the next evaluation.
- R8: Opcode 7 (ROTL) rotates the comparand left by one bit, and opcode 8 (ROTR) rotates it right by one bit. Neither starts a search.
- R9: Opcode 9 (READ), sampled at edge E, places the entry in `rd_data` and its {skip, empty} bits in `stat_vbits` at edge E. Both hold until the next read.
- R10: `free_addr` is the lowest Empty address and `full_flag` is 1 when no entry is Empty. Both are registered, so a validity change at edge E shows after E+1. `free_addr` is 0 when full.
- R11: Reset makes every entry Empty, clears the comparand and the mask, and sets the split to all segments. It clears `match_flag`, `multi_flag`, `match_addr`, `full_flag`, `free_addr`, `rd_data` and `stat_vbits`.
- R12: Opcode 1 (WRITE) stores `cmd_data` in entry `cmd_addr` and leaves its type unchanged. Opcode 0 (NOP), opcodes 10 to 15, and any cycle with `cmd_valid` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Opcode |
| cmd_addr | input | AW | Entry address for WRITE, SETV, READ |
| cmd_vtype | input | 2 | Validity type for SETV and SEARCH |
| cmd_data | input | WIDTH | Entry data, comparand, mask or split |
| rd_data | output | WIDTH | Entry read back |
| stat_vbits | output | 2 | {skip, empty} of the entry read |
| match_flag | output | 1 | At least one hit |
| multi_flag | output | 1 | More than one hit |
| match_addr | output | AW | Lowest hitting address |
| full_flag | output | 1 | No Empty entry |
| free_addr | output | AW | Lowest Empty address |

## Verification
A search evaluation and a table update can land on the same edge. This happens when a write or validity change is issued in the clock right after a comparand load or a search command. The bench provokes this case with back-to-back commands in both orders. It expects the result computed from the table as it stood before the update, and then confirms the update with a fresh search. Back-to-back searches of different types are also checked, one result per cycle, each judged against its own type.

// File: rtl/vcam_pkg.sv
package vcam_pkg;

    typedef enum logic [1:0] {
        VT_VALID = 2'b00,
        VT_EMPTY = 2'b01,
        VT_SKIP  = 2'b10,
        VT_RAM   = 2'b11
    } vtype_e;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_WRITE  = 4'd1,
        OP_CMPND  = 4'd2,
        OP_MASK   = 4'd3,
        OP_SPLIT  = 4'd4,
        OP_SETV   = 4'd5,
        OP_SEARCH = 4'd6,
        OP_ROTL   = 4'd7,
        OP_ROTR   = 4'd8,
        OP_READ   = 4'd9
    } op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SEARCH = 1'b1
    } st_e;

endpackage

// File: rtl/vcam_ctrl.sv
module vcam_ctrl
    import vcam_pkg::*;
#(
    parameter int WIDTH = 64,
    parameter int SEG_W = 16,
    localparam int SEGS = WIDTH / SEG_W,
    localparam int SPW  = (SEGS > 1) ? $clog2(SEGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [1:0]       cmd_vtype,
    input  logic [WIDTH-1:0] cmd_data,
    output logic             wr_en,
    output logic             setv_en,
    output logic             rd_en,
    output logic             eval_en,
    output logic [1:0]       srch_type,
    output logic [WIDTH-1:0] key,
    output logic [WIDTH-1:0] care
);

    st_e              st_q, st_nx;
    vtype_e           typ_q;
    logic             trig;
    vtype_e           trig_type;
    logic [WIDTH-1:0] cmp_q;
    logic [WIDTH-1:0] mask_q;
    logic [SPW-1:0]   split_q;
    logic [SEGS-1:0]  seg_on;

    // command decode
    always_comb begin
        trig      = 1'b0;
        trig_type = VT_VALID;
        wr_en     = 1'b0;
        setv_en   = 1'b0;
        rd_en     = 1'b0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_CMPND, OP_MASK, OP_SPLIT: trig = 1'b1;
                OP_SEARCH: begin
                    trig      = 1'b1;
                    trig_type = vtype_e'(cmd_vtype);
                end
                OP_WRITE: wr_en   = 1'b1;
                OP_SETV:  setv_en = 1'b1;
                OP_READ:  rd_en   = 1'b1;
                default: ;
            endcase
        end
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE:   st_nx = trig ? ST_SEARCH : ST_IDLE;
            ST_SEARCH: st_nx = trig ? ST_SEARCH : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            typ_q <= VT_VALID;
        end else begin
            st_q <= st_nx;
            if (trig) typ_q <= trig_type;
        end
    end

    // outputs of the state machine
    always_comb begin
        eval_en   = (st_q == ST_SEARCH);
        srch_type = typ_q;
    end

    // key registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q   <= '0;
            mask_q  <= '0;
            split_q <= SPW'(SEGS - 1);
        end else if (cmd_valid) begin
            case (cmd_op)
                OP_CMPND: cmp_q   <= cmd_data;
                OP_MASK:  mask_q  <= cmd_data;
                OP_SPLIT: split_q <= cmd_data[SPW-1:0];
                OP_ROTL:  cmp_q   <= {cmp_q[WIDTH-2:0], cmp_q[WIDTH-1]};
                OP_ROTR:  cmp_q   <= {cmp_q[0], cmp_q[WIDTH-1:1]};
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < SEGS; g++) begin : g_seg
        assign seg_on[g] = (SPW'(g) <= split_q);
        assign care[g*SEG_W +: SEG_W] = ~mask_q[g*SEG_W +: SEG_W] & {SEG_W{seg_on[g]}};
    end

    assign key = cmp_q;

endmodule

// File: rtl/vcam_array.sv
module vcam_array
    import vcam_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             setv_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [1:0]       vtype_in,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] key,
    input  logic [WIDTH-1:0] care,
    input  logic [1:0]       sel_type,
    output logic [DEPTH-1:0] hit_vec,
    output logic [DEPTH-1:0] empty_vec,
    output logic [WIDTH-1:0] rd_data,
    output logic [1:0]       rd_vt
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [1:0]       vt  [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) vt[i] <= VT_EMPTY;
        end else if (setv_en) begin
            vt[addr] <= vtype_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_vt   <= '0;
        end else if (rd_en) begin
            rd_data <= mem[addr];
            rd_vt   <= vt[addr];
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign hit_vec[i]   = (vt[i] == sel_type) && (((mem[i] ^ key) & care) == '0);
        assign empty_vec[i] = (vt[i] == VT_EMPTY);
    end

endmodule

// File: rtl/vcam_prio.sv
module vcam_prio #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic          multi,
    output logic [IW-1:0] idx
);

    always_comb begin
        any   = |vec;
        multi = |(vec & (vec - N'(1)));
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/vcam_top.sv
module vcam_top
    import vcam_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 64,
    parameter int SEG_W = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [1:0]       cmd_vtype,
    input  logic [WIDTH-1:0] cmd_data,
    output logic [WIDTH-1:0] rd_data,
    output logic [1:0]       stat_vbits,
    output logic             match_flag,
    output logic             multi_flag,
    output logic [AW-1:0]    match_addr,
    output logic             full_flag,
    output logic [AW-1:0]    free_addr
);

    logic             wr_en, setv_en, rd_en, eval_en;
    logic [1:0]       srch_type;
    logic [WIDTH-1:0] key, care;
    logic [DEPTH-1:0] hit_vec, empty_vec;
    logic             hit_any, hit_multi, emp_any, emp_multi;
    logic [AW-1:0]    hit_idx, emp_idx;

    vcam_ctrl #(.WIDTH(WIDTH), .SEG_W(SEG_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_vtype (cmd_vtype),
        .cmd_data  (cmd_data),
        .wr_en     (wr_en),
        .setv_en   (setv_en),
        .rd_en     (rd_en),
        .eval_en   (eval_en),
        .srch_type (srch_type),
        .key       (key),
        .care      (care)
    );

    vcam_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) array_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .setv_en   (setv_en),
        .rd_en     (rd_en),
        .addr      (cmd_addr),
        .vtype_in  (cmd_vtype),
        .wdata     (cmd_data),
        .key       (key),
        .care      (care),
        .sel_type  (srch_type),
        .hit_vec   (hit_vec),
        .empty_vec (empty_vec),
        .rd_data   (rd_data),
        .rd_vt     (stat_vbits)
    );

    vcam_prio #(.N(DEPTH)) hit_enc_i (
        .vec   (hit_vec),
        .any   (hit_any),
        .multi (hit_multi),
        .idx   (hit_idx)
    );

    vcam_prio #(.N(DEPTH)) free_enc_i (
        .vec   (empty_vec),
        .any   (emp_any),
        .multi (emp_multi),
        .idx   (emp_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_flag <= 1'b0;
            multi_flag <= 1'b0;
            match_addr <= '0;
        end else if (eval_en) begin
            match_flag <= hit_any;
            multi_flag <= hit_multi;
            match_addr <= hit_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_flag <= 1'b0;
            free_addr <= '0;
        end else begin
            full_flag <= ~emp_any;
            free_addr <= emp_idx;
        end
    end

    logic unused_ok;
    assign unused_ok = emp_multi;

endmodule

// File: rtl/vcam_chk.sv
module vcam_chk #(
    parameter int AW    = 4,
    parameter int WIDTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [3:0]       cmd_op,
    input logic [WIDTH-1:0] rd_data,
    input logic [1:0]       stat_vbits,
    input logic             match_flag,
    input logic             multi_flag,
    input logic [AW-1:0]    match_addr,
    input logic             full_flag,
    input logic [AW-1:0]    free_addr
);

    logic [1:0] arm_cnt;
    logic       srch_q1, srch_q2, rd_q;
    logic       armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_cnt <= '0;
            srch_q1 <= 1'b0;
            srch_q2 <= 1'b0;
            rd_q    <= 1'b0;
        end else begin
            if (arm_cnt != 2'd3) arm_cnt <= arm_cnt + 2'd1;
            srch_q1 <= cmd_valid && (cmd_op inside {4'd2, 4'd3, 4'd4, 4'd6});
            srch_q2 <= srch_q1;
            rd_q    <= cmd_valid && (cmd_op == 4'd9);
        end
    end

    assign armed = (arm_cnt == 2'd3);

    p_multi_needs_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        multi_flag |-> match_flag);

    p_addr_zero_nohit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !match_flag |-> (match_addr == '0));

    p_full_free_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        full_flag |-> (free_addr == '0));

    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !srch_q2) |-> ($stable(match_flag) && $stable(multi_flag) && $stable(match_addr)));

    p_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !rd_q) |-> ($stable(rd_data) && $stable(stat_vbits)));

endmodule

bind vcam_top vcam_chk #(.AW(AW), .WIDTH(WIDTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .rd_data    (rd_data),
    .stat_vbits (stat_vbits),
    .match_flag (match_flag),
    .multi_flag (multi_flag),
    .match_addr (match_addr),
    .full_flag  (full_flag),
    .free_addr  (free_addr)
);

// File: tb/vcam_top_tb.sv
module vcam_top_tb_top;

    localparam int DEPTH = 16;
    localparam int WIDTH = 64;
    localparam int AW    = 4;

    localparam logic [3:0] C_NOP = 4'd0, C_WRITE = 4'd1, C_CMPND = 4'd2, C_MASK = 4'd3,
                           C_SPLIT = 4'd4, C_SETV = 4'd5, C_SEARCH = 4'd6, C_ROTL = 4'd7,
                           C_ROTR = 4'd8, C_READ = 4'd9;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cmd_valid;
    logic [3:0]       cmd_op;
    logic [AW-1:0]    cmd_addr;
    logic [1:0]       cmd_vtype;
    logic [WIDTH-1:0] cmd_data;
    logic [WIDTH-1:0] rd_data;
    logic [1:0]       stat_vbits;
    logic             match_flag, multi_flag, full_flag;
    logic [AW-1:0]    match_addr, free_addr;

    always #5 clk = ~clk;

    vcam_top dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_vtype(cmd_vtype), .cmd_data(cmd_data),
        .rd_data(rd_data), .stat_vbits(stat_vbits), .match_flag(match_flag),
        .multi_flag(multi_flag), .match_addr(match_addr), .full_flag(full_flag),
        .free_addr(free_addr)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [WIDTH-1:0] m_mem [DEPTH];
    logic [1:0]       m_vt  [DEPTH];
    logic [WIDTH-1:0] m_cmp, m_mask;
    int               m_split;

    task automatic chk(input string req, input string what,
                       input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input int addr, input logic [1:0] vt,
                         input logic [WIDTH-1:0] data);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = AW'(addr);
        cmd_vtype = vt;
        cmd_data  = data;
        @(negedge clk);
    endtask

    task automatic idle();
        cmd_valid = 1'b0;
        cmd_op    = C_NOP;
        @(negedge clk);
    endtask

    function automatic logic [WIDTH-1:0] pat(input int i);
        return {16'(i * 257), 16'hC3C3 ^ 16'(i), 16'(i >> 3), 16'(i & 1)};
    endfunction

    task automatic model(input logic [1:0] ty, output logic f, output logic mm,
                         output logic [AW-1:0] a);
        int cnt = 0;
        a = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            bit hit = (m_vt[i] == ty);
            for (int b = 0; b < WIDTH; b++)
                if (!m_mask[b] && (b / 16) <= m_split && m_mem[i][b] != m_cmp[b]) hit = 0;
            if (hit) begin cnt++; a = AW'(i); end
        end
        f  = (cnt > 0);
        mm = (cnt > 1);
    endtask

    task automatic check_search(input string req, input logic [1:0] ty);
        logic f, mm;
        logic [AW-1:0] a;
        model(ty, f, mm, a);
        chk(req, "match_flag", 64'(match_flag), 64'(f));
        chk(req, "multi_flag", 64'(multi_flag), 64'(mm));
        chk(req, "match_addr", 64'(match_addr), 64'(a));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic f0, mm0;
        logic [AW-1:0] a0;
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = C_NOP; cmd_addr = '0;
        cmd_vtype = '0; cmd_data = '0;
        for (int i = 0; i < DEPTH; i++) m_vt[i] = 2'b01;
        m_cmp = '0; m_mask = '0; m_split = 3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk("R11", "match_flag", 64'(match_flag), 0);
        chk("R11", "multi_flag", 64'(multi_flag), 0);
        chk("R11", "match_addr", 64'(match_addr), 0);
        chk("R11", "full_flag", 64'(full_flag), 0);
        chk("R11", "free_addr", 64'(free_addr), 0);
        chk("R11", "rd_data", rd_data, 0);
        chk("R11", "stat_vbits", 64'(stat_vbits), 0);

        // R12 write table
        for (int i = 0; i < DEPTH; i++) begin
            drive(C_WRITE, i, 2'b00, pat(i));
            m_mem[i] = pat(i);
        end
        idle();

        // R10 fill sweep
        for (int j = 0; j < DEPTH; j++) begin
            drive(C_SETV, j, 2'b00, '0);
            m_vt[j] = 2'b00;
            idle();
            chk("R10", "full_flag", 64'(full_flag), 64'(j == DEPTH - 1));
            chk("R10", "free_addr", 64'(free_addr), (j == DEPTH - 1) ? 0 : 64'(j + 1));
        end
        // R1 mixed types: type = i mod 4
        for (int i = 0; i < DEPTH; i++) begin
            drive(C_SETV, i, 2'(i % 4), '0);
            m_vt[i] = 2'(i % 4);
        end
        idle(); idle();
        chk("R10", "full_flag", 64'(full_flag), 0);
        chk("R10", "free_addr", 64'(free_addr), 1);

        // R9 / R1 read back
        for (int i = 0; i < DEPTH; i++) begin
            drive(C_READ, i, 2'b00, '0);
            chk("R9", "rd_data", rd_data, m_mem[i]);
            chk("R1", "stat_vbits", 64'(stat_vbits), 64'(m_vt[i]));
        end
        idle();

        // R2 R3 R4 sweeps over split, comparand and type
        for (int s = 0; s < 4; s++) begin
            drive(C_SPLIT, 0, 2'b00, 64'(s)); m_split = s; idle();
            check_search("R4", 2'b00);
            for (int k = 0; k < DEPTH; k++) begin
                drive(C_CMPND, 0, 2'b00, m_mem[k]); m_cmp = m_mem[k]; idle();
                check_search("R2", 2'b00);
                for (int t = 0; t < 4; t++) begin
                    drive(C_SEARCH, 0, 2'(t), '0); idle();
                    check_search("R3", 2'(t));
                end
            end
        end

        // R5 mask sweep, split is 3
        for (int b = 0; b < WIDTH; b++) begin
            drive(C_CMPND, 0, 2'b00, m_mem[4] ^ (64'd1 << b)); m_cmp = m_mem[4] ^ (64'd1 << b); idle();
            check_search("R5", 2'b00);
            drive(C_MASK, 0, 2'b00, 64'd1 << b); m_mask = 64'd1 << b; idle();
            check_search("R5", 2'b00);
        end
        drive(C_MASK, 0, 2'b00, '1); m_mask = '1; idle();
        check_search("R5", 2'b00);
        drive(C_SEARCH, 0, 2'b10, '0); idle();
        check_search("R5", 2'b10);
        drive(C_MASK, 0, 2'b00, '0); m_mask = '0; idle();

        // R8 rotation
        drive(C_CMPND, 0, 2'b00, {m_mem[8][0], m_mem[8][63:1]});
        m_cmp = {m_mem[8][0], m_mem[8][63:1]}; idle();
        check_search("R8", 2'b00);
        model(2'b00, f0, mm0, a0);
        drive(C_ROTL, 0, 2'b00, '0); m_cmp = m_mem[8]; idle(); idle();
        chk("R8", "match_flag after rotate only", 64'(match_flag), 64'(f0));
        drive(C_SEARCH, 0, 2'b00, '0); idle();
        check_search("R8", 2'b00);
        chk("R8", "match_addr rotated back", 64'(match_addr), 8);
        drive(C_ROTL, 0, 2'b00, '0);
        drive(C_ROTR, 0, 2'b00, '0);
        drive(C_SEARCH, 0, 2'b00, '0); idle();
        check_search("R8", 2'b00);
        chk("R8", "match_flag after left then right", 64'(match_flag), 1);

        // R7 search evaluation coinciding with a write
        drive(C_CMPND, 0, 2'b00, m_mem[12]); m_cmp = m_mem[12];
        model(2'b00, f0, mm0, a0);
        drive(C_WRITE, 12, 2'b00, ~m_mem[12]);
        chk("R7", "match_flag old contents", 64'(match_flag), 64'(f0));
        chk("R7", "match_addr old contents", 64'(match_addr), 64'(a0));
        m_mem[12] = ~m_mem[12];
        idle();
        drive(C_SEARCH, 0, 2'b00, '0); idle();
        check_search("R7", 2'b00);
        chk("R7", "match_flag after write", 64'(match_flag), 0);
        // R7 search coinciding with a validity change
        drive(C_CMPND, 0, 2'b00, m_mem[4]); m_cmp = m_mem[4];
        model(2'b00, f0, mm0, a0);
        drive(C_SETV, 4, 2'b10, '0);
        chk("R7", "match_addr before setv", 64'(match_addr), 64'(a0));
        chk("R7", "match_flag before setv", 64'(match_flag), 1);
        m_vt[4] = 2'b10;
        idle();
        drive(C_SEARCH, 0, 2'b10, '0); idle();
        check_search("R7", 2'b10);
        // R7 back-to-back searches of two types
        drive(C_SEARCH, 0, 2'b10, '0);
        drive(C_SEARCH, 0, 2'b00, '0);
        check_search("R7", 2'b10);
        idle();
        check_search("R7", 2'b00);

        // R12 ignored commands
        model(2'b00, f0, mm0, a0);
        drive(4'd12, 3, 2'b01, '1);
        drive(4'd15, 0, 2'b01, '1);
        cmd_valid = 1'b0; cmd_op = C_WRITE; cmd_addr = '0; cmd_data = '1;
        @(negedge clk);
        cmd_op = C_CMPND; @(negedge clk);
        idle();
        chk("R12", "match_flag unchanged", 64'(match_flag), 64'(f0));
        drive(C_READ, 0, 2'b00, '0);
        chk("R12", "entry 0 data", rd_data, m_mem[0]);
        drive(C_READ, 3, 2'b00, '0);
        chk("R12", "entry 3 type", 64'(stat_vbits), 64'(m_vt[3]));
        drive(C_SEARCH, 0, 2'b00, '0); idle();
        check_search("R12", 2'b00);

        idle();
        finish_run();
    end

endmodule